// File: doc/BRIEF.md
# Matrix-Vector Multiply-Add with Saturation

This block forms three accumulator lanes from a 3×3 matrix of signed 16-bit coefficients, a signed 16-bit three-element vector and a signed 32-bit three-element translation. Each lane's translation is scaled up by 4096 (a left shift of 12). The lane then adds the dot product of one matrix row with the vector. The sum is held at a precision wide enough to tell when it leaves the signed 44-bit range. A shift-select input can divide the result by 4096 with an arithmetic right shift before it becomes the 32-bit lane result.

Each 32-bit lane result is then clamped into a 16-bit lane output. The upper bound is 0x7FFF. The lower bound is −0x8000, or zero when limit mode is set. Every overflow and every clamp is recorded in a 32-bit flag word. A one-cycle start pulse captures all results together, and they stay unchanged until the next start. Selecting which matrix, vector or translation feeds the block is done elsewhere.

Top module: `mvma_sat`

## Requirements
- R1: With shift_i=0, lane r of mac_o (bits [32r+31:32r]) equals the low 32 bits of tr_r·4096 + Σc mx(r,c)·vec(c). Here mx(r,c) is mx_i[16(3r+c)+15:16(3r+c)], vec(c) is vec_i[16c+15:16c] and tr_r is tr_i[32r+31:32r], all signed.
- R2: With shift_i=1, lane r of mac_o is the low 32 bits of that same full sum after an arithmetic right shift by 12.
- R3: When the full sum of lane 0, 1 or 2 is greater than 2^43−1, flag_o bit 30, 29 or 28 is set, respectively.
- R4: When the full sum of lane 0, 1 or 2 is below −2^43, flag_o bit 27, 26 or 25 is set, respectively, and bit 31 is set as well.
- R5: With lm_i=0, lane r of ir_o (bits [16r+15:16r]) is 0x7FFF when the signed lane r mac_o is ≥ 0x8000, is 0x8000 when mac_o is < −0x8000, and is otherwise the low 16 bits of mac_o.
- R6: With lm_i=1, any negative lane value gives an ir_o lane of 0, and the upper clamp is unchanged.
- R7: A clamp of ir lane 0 sets flag_o bits 24 and 31. A clamp of ir lane 1 sets flag_o bits 23 and 31.
- R8: A clamp of ir lane 2 sets flag_o bit 22 and does not by itself set bit 31.
- R9: When tr_i is zero and shift_i=1, flag_o bits 30..25 are all zero for any matrix and vector.
- R10: The results of a start_i pulse appear on mac_o, ir_o and flag_o in the cycle after that edge, and valid_o is high for exactly that cycle. flag_o is rewritten completely by each operation. Without start_i, all outputs hold.
- R11: While reset is asserted, mac_o, ir_o, flag_o and valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the results of the current operands |
| mx_i | input | 144 | Matrix, element (r,c) at bits [16(3r+c)+15:16(3r+c)] |
| vec_i | input | 48 | Vector, element c at bits [16c+15:16c] |
| tr_i | input | 96 | Translation, lane r at bits [32r+31:32r] |
| shift_i | input | 1 | 1: divide the sum by 4096 before storing |
| lm_i | input | 1 | 1: lower clamp of ir is 0 |
| valid_o | output | 1 | High in the cycle the results are new |
| mac_o | output | 96 | Lane results, 32 bits each |
| ir_o | output | 48 | Clamped lane outputs, 16 bits each |
| flag_o | output | 32 | Overflow and clamp flags |

## Verification
Every result of an operation is due one clock edge after its start edge. The lane results, the clamped outputs and the flags all go through the same register, and valid_o marks that cycle. The driver applies operands and start at a falling edge and queues the expected lane results, clamps and flags. The monitor pops one entry at each falling edge where valid_o is high, which is half a cycle after the capturing edge. A back-to-back pair of operations checks that the flags are rewritten completely. An idle stretch checks that the outputs hold and that valid_o stays low.

// File: rtl/mvma_pkg.sv
package mvma_pkg;
  localparam int LANES     = 3;
  localparam int FLAG_W    = 32;
  localparam int FLG_SUM   = 31;  // summary bit
  localparam int FLG_POS0  = 30;  // lane l positive overflow at FLG_POS0-l
  localparam int FLG_NEG0  = 27;  // lane l negative overflow at FLG_NEG0-l
  localparam int FLG_IR0   = 24;  // lane l clamp at FLG_IR0-l
  localparam int IR_SUM_LN = 2;   // lanes below this feed the summary on clamp
endpackage

// File: rtl/mvma_lane.sv
module mvma_lane import mvma_pkg::*; #(
  parameter int ELEM_W = 16,
  parameter int TR_W   = 32,
  parameter int FRAC   = 12,
  parameter int ACC_W  = 44,
  parameter int MAC_W  = 32
) (
  input  logic [LANES*ELEM_W-1:0] row_i,
  input  logic [LANES*ELEM_W-1:0] vec_i,
  input  logic [TR_W-1:0]         tr_i,
  input  logic                    shift_i,
  output logic [MAC_W-1:0]        mac_o,
  output logic                    pos_ovf_o,
  output logic                    neg_ovf_o
);
  localparam int PROD_W = 2 * ELEM_W;
  localparam int SUM_W  = ACC_W + 4;
  localparam logic signed [SUM_W-1:0] ACC_MAX = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] ACC_MIN = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  logic signed [SUM_W-1:0] prod_ext [LANES];
  logic signed [SUM_W-1:0] tr_ext;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] sum_sh;

  for (genvar c = 0; c < LANES; c++) begin : g_mul
    logic signed [ELEM_W-1:0] a, b;
    logic signed [PROD_W-1:0] p;
    assign a = row_i[c*ELEM_W +: ELEM_W];
    assign b = vec_i[c*ELEM_W +: ELEM_W];
    assign p = a * b;
    assign prod_ext[c] = {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
  end

  assign tr_ext = {{(SUM_W-TR_W-FRAC){tr_i[TR_W-1]}}, tr_i, {FRAC{1'b0}}};

  always_comb begin
    sum = tr_ext;
    for (int c = 0; c < LANES; c++) sum = sum + prod_ext[c];
  end

  assign sum_sh    = sum >>> FRAC;
  assign mac_o     = shift_i ? sum_sh[MAC_W-1:0] : sum[MAC_W-1:0];
  assign pos_ovf_o = sum > ACC_MAX;
  assign neg_ovf_o = sum < ACC_MIN;
endmodule

// File: rtl/mvma_clamp.sv
module mvma_clamp #(
  parameter int MAC_W = 32,
  parameter int IR_W  = 16
) (
  input  logic [MAC_W-1:0] mac_i,
  input  logic             lm_i,
  output logic [IR_W-1:0]  ir_o,
  output logic             sat_o
);
  localparam logic signed [MAC_W-1:0] HI = {{(MAC_W-IR_W+1){1'b0}}, {(IR_W-1){1'b1}}};
  localparam logic signed [MAC_W-1:0] LO = {{(MAC_W-IR_W+1){1'b1}}, {(IR_W-1){1'b0}}};

  logic signed [MAC_W-1:0] v;
  assign v = mac_i;

  always_comb begin
    sat_o = 1'b1;
    if (v > HI)              ir_o = HI[IR_W-1:0];
    else if (lm_i && v < 0)  ir_o = '0;
    else if (v < LO)         ir_o = LO[IR_W-1:0];
    else begin
      ir_o  = v[IR_W-1:0];
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/mvma_sat.sv
module mvma_sat import mvma_pkg::*; #(
  parameter int ELEM_W = 16,
  parameter int TR_W   = 32,
  parameter int FRAC   = 12,
  parameter int ACC_W  = 44,
  parameter int MAC_W  = 32,
  parameter int IR_W   = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [LANES*LANES*ELEM_W-1:0]   mx_i,
  input  logic [LANES*ELEM_W-1:0]         vec_i,
  input  logic [LANES*TR_W-1:0]           tr_i,
  input  logic                            shift_i,
  input  logic                            lm_i,
  output logic                            valid_o,
  output logic [LANES*MAC_W-1:0]          mac_o,
  output logic [LANES*IR_W-1:0]           ir_o,
  output logic [FLAG_W-1:0]               flag_o
);
  localparam int ROW_W = LANES * ELEM_W;

  logic [LANES*MAC_W-1:0] mac_d;
  logic [LANES*IR_W-1:0]  ir_d;
  logic [LANES-1:0]       pos_ovf, neg_ovf, sat;
  logic [FLAG_W-1:0]      flag_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    mvma_lane #(
      .ELEM_W(ELEM_W), .TR_W(TR_W), .FRAC(FRAC), .ACC_W(ACC_W), .MAC_W(MAC_W)
    ) u_lane (
      .row_i     (mx_i[l*ROW_W +: ROW_W]),
      .vec_i     (vec_i),
      .tr_i      (tr_i[l*TR_W +: TR_W]),
      .shift_i   (shift_i),
      .mac_o     (mac_d[l*MAC_W +: MAC_W]),
      .pos_ovf_o (pos_ovf[l]),
      .neg_ovf_o (neg_ovf[l])
    );
    mvma_clamp #(.MAC_W(MAC_W), .IR_W(IR_W)) u_clamp (
      .mac_i (mac_d[l*MAC_W +: MAC_W]),
      .lm_i  (lm_i),
      .ir_o  (ir_d[l*IR_W +: IR_W]),
      .sat_o (sat[l])
    );
  end

  always_comb begin
    flag_d = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pos_ovf[l]) flag_d[FLG_POS0-l] = 1'b1;
      if (neg_ovf[l]) begin
        flag_d[FLG_NEG0-l] = 1'b1;
        flag_d[FLG_SUM]    = 1'b1;
      end
      if (sat[l]) begin
        flag_d[FLG_IR0-l] = 1'b1;
        if (l < IR_SUM_LN) flag_d[FLG_SUM] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mac_o   <= '0;
      ir_o    <= '0;
      flag_o  <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        mac_o  <= mac_d;
        ir_o   <= ir_d;
        flag_o <= flag_d;
      end
    end
  end
endmodule

// File: rtl/mvma_sat_chk.sv
module mvma_sat_chk import mvma_pkg::*; #(
  parameter int ELEM_W = 16,
  parameter int TR_W   = 32,
  parameter int MAC_W  = 32,
  parameter int IR_W   = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          start_i,
  input logic [LANES*TR_W-1:0]         tr_i,
  input logic                          shift_i,
  input logic                          lm_i,
  input logic                          valid_o,
  input logic [LANES*MAC_W-1:0]        mac_o,
  input logic [LANES*IR_W-1:0]         ir_o,
  input logic [FLAG_W-1:0]             flag_o
);
  assert_valid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  assert_valid_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(mac_o) && $stable(ir_o) && $stable(flag_o)));
  assert_neg_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_o[FLG_NEG0 -: LANES]) |-> flag_o[FLG_SUM]);
  assert_ir3_alone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|flag_o[FLG_POS0:FLG_IR0-1]) |-> !flag_o[FLG_SUM]);
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && shift_i && tr_i == '0) |=> (flag_o[FLG_POS0:FLG_NEG0-LANES+1] == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_lm_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && lm_i) |=> !ir_o[l*IR_W + IR_W-1]);
    assert_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !flag_o[FLG_IR0-l]) |-> (ir_o[l*IR_W +: IR_W] == mac_o[l*MAC_W +: IR_W]));
  end
endmodule

bind mvma_sat mvma_sat_chk #(
  .ELEM_W(ELEM_W), .TR_W(TR_W), .MAC_W(MAC_W), .IR_W(IR_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tr_i(tr_i),
  .shift_i(shift_i), .lm_i(lm_i), .valid_o(valid_o), .mac_o(mac_o),
  .ir_o(ir_o), .flag_o(flag_o)
);

// File: tb/mvma_sat_tb_top.sv
`timescale 1ns/1ps
module mvma_sat_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [143:0] mx_i = '0;
  logic [47:0]  vec_i = '0;
  logic [95:0]  tr_i = '0;
  logic         shift_i = 1'b0;
  logic         lm_i = 1'b0;
  logic         valid_o;
  logic [95:0]  mac_o;
  logic [47:0]  ir_o;
  logic [31:0]  flag_o;

  always #5 clk_i = ~clk_i;

  mvma_sat dut_i (.*);

  typedef struct {
    string       tag;
    logic [95:0] mac;
    logic [47:0] ir;
    logic [31:0] fl;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [95:0] last_mac = '0;

  localparam logic signed [47:0] LIM_HI = 48'h07FF_FFFF_FFFF;
  localparam logic signed [47:0] LIM_LO = 48'hF800_0000_0000;

  task automatic check(string tag, string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(string tag, logic [143:0] mx, logic [47:0] v,
                                 logic [95:0] tr, logic sh, logic lm);
    exp_t e;
    e.tag = tag; e.mac = '0; e.ir = '0; e.fl = '0;
    for (int l = 0; l < 3; l++) begin
      logic signed [47:0] s;
      logic signed [47:0] ss;
      logic signed [31:0] m;
      s = {{4{tr[l*32+31]}}, tr[l*32 +: 32], 12'h000};
      for (int c = 0; c < 3; c++) begin
        logic signed [31:0] p;
        p = $signed(mx[(l*3+c)*16 +: 16]) * $signed(v[c*16 +: 16]);
        s = s + {{16{p[31]}}, p};
      end
      ss = s >>> 12;
      m = sh ? ss[31:0] : s[31:0];
      e.mac[l*32 +: 32] = m;
      if (s > LIM_HI) e.fl[30-l] = 1'b1;
      if (s < LIM_LO) begin e.fl[27-l] = 1'b1; e.fl[31] = 1'b1; end
      if (m > 32'sd32767) begin
        e.ir[l*16 +: 16] = 16'h7FFF; e.fl[24-l] = 1'b1; if (l < 2) e.fl[31] = 1'b1;
      end else if (lm && m < 0) begin
        e.ir[l*16 +: 16] = 16'h0000; e.fl[24-l] = 1'b1; if (l < 2) e.fl[31] = 1'b1;
      end else if (m < -32'sd32768) begin
        e.ir[l*16 +: 16] = 16'h8000; e.fl[24-l] = 1'b1; if (l < 2) e.fl[31] = 1'b1;
      end else e.ir[l*16 +: 16] = m[15:0];
    end
    return e;
  endfunction

  // Driver: called at a falling edge; leaves start low after one cycle.
  task automatic run_op(string tag, logic [143:0] mx, logic [47:0] v,
                        logic [95:0] tr, logic sh, logic lm);
    q.push_back(model(tag, mx, v, tr, sh, lm));
    mx_i = mx; vec_i = v; tr_i = tr; shift_i = sh; lm_i = lm; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  function automatic logic [143:0] mx_all(logic [15:0] x);
    logic [143:0] r;
    for (int i = 0; i < 9; i++) r[i*16 +: 16] = x;
    return r;
  endfunction

  // Monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o && !done) begin
      if (q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "mac", mac_o, e.mac);
        check(e.tag, "ir", {48'h0, ir_o}, {48'h0, e.ir});
        check(e.tag, "flag", {64'h0, flag_o}, {64'h0, e.fl});
        last_mac = e.mac;
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [143:0] diag;
    diag = '0;
    diag[0*16 +: 16] = 16'd1; diag[4*16 +: 16] = 16'd2; diag[8*16 +: 16] = 16'hFFFD;
    diag[1*16 +: 16] = 16'h0100;

    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11", "reset", {valid_o, flag_o, ir_o}, '0);
    check("R11", "reset mac", mac_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op("R1", diag, {16'd300, 16'hFF38, 16'd100}, {32'hFFFF_FFFD, 32'd2, 32'd1}, 1'b0, 1'b0);
    run_op("R2", diag, {16'd300, 16'hFF38, 16'd100}, {32'hFFFF_FFFD, 32'd2, 32'd1}, 1'b1, 1'b0);
    run_op("R2", mx_all(16'h4000), {16'h1234, 16'h8000, 16'h7FFF}, {32'h0, 32'hFFFF_F000, 32'h10}, 1'b1, 1'b0);
    run_op("R3", mx_all(16'h7FFF), {3{16'h7FFF}}, {3{32'h7FFF_FFFF}}, 1'b0, 1'b0);
    run_op("R4", mx_all(16'h7FFF), {3{16'h8000}}, {3{32'h8000_0000}}, 1'b1, 1'b0);
    run_op("R5", '0, '0, {32'h0000_1234, 32'hFFFF_7000, 32'h0000_9000}, 1'b1, 1'b0);
    run_op("R6", '0, '0, {32'hFFFF_FFFB, 32'hFFFF_7000, 32'h0000_9000}, 1'b1, 1'b1);
    run_op("R6", '0, '0, {32'h0000_7FFF, 32'h0000_0000, 32'h0000_0001}, 1'b1, 1'b1);
    run_op("R7", '0, '0, {32'h0000_0000, 32'h0000_8000, 32'h0000_0005}, 1'b1, 1'b0);
    run_op("R8", '0, '0, {32'hFFFF_7FFF, 32'h0000_0005, 32'h0000_0000}, 1'b1, 1'b0);
    run_op("R8", '0, '0, {32'h0000_8000, 32'h0000_0005, 32'hFFFF_8000}, 1'b1, 1'b1);
    run_op("R9", mx_all(16'h8000), {3{16'h8000}}, '0, 1'b1, 1'b0);
    run_op("R9", mx_all(16'h7FFF), {3{16'h8000}}, '0, 1'b1, 1'b1);
    // R10 back-to-back: flag-heavy then flag-free operation
    run_op("R10", mx_all(16'h7FFF), {3{16'h7FFF}}, {3{32'h7FFF_FFFF}}, 1'b0, 1'b0);
    run_op("R10", '0, '0, {32'd3, 32'd2, 32'd1}, 1'b1, 1'b0);

    // R10 hold: operands change without start
    mx_i = mx_all(16'h1111); tr_i = {3{32'h0055_0000}};
    @(negedge clk_i);
    repeat (4) begin
      @(negedge clk_i);
      check("R10", "idle valid", {95'h0, valid_o}, '0);
      check("R10", "idle mac", mac_o, last_mac);
    end
    check("R10", "queue drained", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule